// File: doc/BRIEF.md
# SATA Diagnostic Error Status Register

This block holds the diagnostic error status word for each port of a serial ATA host controller. The PHY and link layers signal problems as one-cycle event strobes: symbol decode faults, running-disparity faults, CRC faults, handshake faults, unrecognised frame types and ComWake detection. A PHY-ready level is also watched for changes. Each event sets a sticky bit in the upper half of its port's 32-bit word. The bit stays set until software clears it by writing a one to that position.

A simple register bus reaches the words. The bus has an address, a write strobe with write data, and a read strobe. Read data is returned from a register one cycle later. Each port's word sits at a fixed offset. Every offset outside that set reads as zero and ignores writes. The lower half-word and all diagnostic positions without a source are tied to zero.

Top module: `sata_diag_err_regs`

## Requirements
- R1: After reset every port's word reads 0x0000_0000.
- R2: Only bits 25 (F), 22 (H), 21 (C), 19 (B), 18 (W) and 16 (N) can ever read as one. Bits 31:26, 24, 23, 20, 17 and 15:0 always read zero.
- R3: A decode-error strobe or a disparity-error strobe sets bit 19 (B). Bit 20 (D) stays zero.
- R4: A CRC strobe sets bit 21 (C). A handshake strobe sets bit 22 (H). An unrecognised-frame strobe sets bit 25 (F). A ComWake strobe sets bit 18 (W). Each bit stays set until it is cleared.
- R5: Bit 16 (N) is set one cycle after the PHY-ready input differs from its value in the previous cycle, on a rising or a falling edge. The stored previous value resets to 0.
- R6: A write to a port's offset clears each implemented bit whose write-data bit is 1. Bits written with 0, and the words of all other ports, are unchanged.
- R7: When an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R8: Port p answers at offset 0x108 + 0x80·(p mod 2) + 0x200·(p div 2), which gives 0x108, 0x188, 0x308 and 0x388.
- R9: A read of an unmapped offset returns zero. A write to an unmapped offset changes no port's word.
- R10: Read data appears on the cycle after the read strobe and holds its value until the next read. It shows the word as it stood before any update made in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised to clk |
| ev_decode | input | NUM_PORTS | Per-port 10b/8b decode error strobe |
| ev_disparity | input | NUM_PORTS | Per-port disparity error strobe |
| ev_crc | input | NUM_PORTS | Per-port CRC error strobe |
| ev_handshake | input | NUM_PORTS | Per-port handshake error strobe |
| ev_bad_frame | input | NUM_PORTS | Per-port unrecognised frame type strobe |
| ev_comwake | input | NUM_PORTS | Per-port ComWake detect strobe |
| phy_ready | input | NUM_PORTS | Per-port PHY-ready level |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe (write-1-to-clear) |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with its default values: four ports and a 12-bit offset. Four ports is the full set of offsets from R8. This lets the bench cover both the 0x80 step and the 0x200 step of the address formula. It also lets the bench check that clearing one port leaves the other three alone. The 12-bit width is enough to reach the unmapped offsets next to the mapped ones, such as 0x100, 0x10C and 0x208.

// File: rtl/sata_diag_pkg.sv
package sata_diag_pkg;

  // Positions inside the upper half-word (add 16 for the full word).
  localparam int DG_N = 0;  // PHY-ready change
  localparam int DG_W = 2;  // ComWake seen
  localparam int DG_B = 3;  // decode or disparity fault
  localparam int DG_C = 5;  // CRC fault
  localparam int DG_H = 6;  // handshake fault
  localparam int DG_F = 9;  // unrecognised frame type

  localparam logic [15:0] DG_IMPL = 16'h026D;

  localparam int WORD_BASE  = 'h108;
  localparam int PAIR_STEP  = 'h80;
  localparam int GROUP_STEP = 'h200;

  function automatic int port_offset(input int p);
    return WORD_BASE + PAIR_STEP * (p % 2) + GROUP_STEP * (p / 2);
  endfunction

  function automatic logic addr_mapped(input int addr, input int nports);
    logic hit;
    hit = 1'b0;
    for (int p = 0; p < nports; p++)
      if (addr == port_offset(p)) hit = 1'b1;
    return hit;
  endfunction

endpackage

// File: rtl/sata_diag_addr_dec.sv
module sata_diag_addr_dec #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_PORTS-1:0] hit
);
  import sata_diag_pkg::*;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(port_offset(p));
    assign hit[p] = (addr == OFFS);
  end

endmodule

// File: rtl/sata_diag_port_bits.sv
module sata_diag_port_bits (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_decode,
  input  logic        ev_disparity,
  input  logic        ev_crc,
  input  logic        ev_handshake,
  input  logic        ev_bad_frame,
  input  logic        ev_comwake,
  input  logic        phy_ready,
  input  logic        clr_en,
  input  logic [15:0] clr_mask,
  output logic [15:0] diag
);
  import sata_diag_pkg::*;

  logic        phy_prev_q;
  logic [15:0] diag_q;
  logic [15:0] set_vec;
  logic [15:0] clr_vec;
  logic [15:0] diag_nxt;

  always_comb begin
    set_vec        = '0;
    set_vec[DG_N]  = phy_ready ^ phy_prev_q;
    set_vec[DG_W]  = ev_comwake;
    set_vec[DG_B]  = ev_decode | ev_disparity;
    set_vec[DG_C]  = ev_crc;
    set_vec[DG_H]  = ev_handshake;
    set_vec[DG_F]  = ev_bad_frame;
    clr_vec        = clr_en ? (clr_mask & DG_IMPL) : '0;
    // a fresh event wins over a clear in the same cycle
    diag_nxt       = ((diag_q & ~clr_vec) | set_vec) & DG_IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diag_q     <= '0;
      phy_prev_q <= 1'b0;
    end else begin
      diag_q     <= diag_nxt;
      phy_prev_q <= phy_ready;
    end
  end

  assign diag = diag_q;

endmodule

// File: rtl/sata_diag_err_regs.sv
module sata_diag_err_regs #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] ev_decode,
  input  logic [NUM_PORTS-1:0] ev_disparity,
  input  logic [NUM_PORTS-1:0] ev_crc,
  input  logic [NUM_PORTS-1:0] ev_handshake,
  input  logic [NUM_PORTS-1:0] ev_bad_frame,
  input  logic [NUM_PORTS-1:0] ev_comwake,
  input  logic [NUM_PORTS-1:0] phy_ready,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_rd,
  output logic [31:0]          bus_rdata
);

  logic [NUM_PORTS-1:0]       hit;
  logic [NUM_PORTS-1:0][15:0] diag_q;
  logic [31:0]                rd_word;
  logic [31:0]                rdata_q;

  sata_diag_addr_dec #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .addr(bus_addr),
    .hit (hit)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    sata_diag_port_bits u_bits (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_decode   (ev_decode[p]),
      .ev_disparity(ev_disparity[p]),
      .ev_crc      (ev_crc[p]),
      .ev_handshake(ev_handshake[p]),
      .ev_bad_frame(ev_bad_frame[p]),
      .ev_comwake  (ev_comwake[p]),
      .phy_ready   (phy_ready[p]),
      .clr_en      (bus_wr & hit[p]),
      .clr_mask    (bus_wdata[31:16]),
      .diag        (diag_q[p])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (hit[p]) rd_word = {diag_q[p], 16'h0000};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/sata_diag_err_chk.sv
module sata_diag_err_chk #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_PORTS-1:0]       ev_decode,
  input logic [NUM_PORTS-1:0]       ev_disparity,
  input logic [NUM_PORTS-1:0]       ev_crc,
  input logic [NUM_PORTS-1:0]       ev_handshake,
  input logic [NUM_PORTS-1:0]       ev_bad_frame,
  input logic [NUM_PORTS-1:0]       ev_comwake,
  input logic [NUM_PORTS-1:0]       phy_ready,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [31:0]                bus_rdata,
  input logic [NUM_PORTS-1:0][15:0] diag_q
);
  import sata_diag_pkg::*;

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~{DG_IMPL, 16'h0000}) == 32'h0); // R2

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !addr_mapped(int'(bus_addr), NUM_PORTS)) |=> bus_rdata == 32'h0); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R10

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_DISPARITY_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_decode[p] || ev_disparity[p]) |=> (diag_q[p][DG_B] && !diag_q[p][4])); // R3

    AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_crc[p] || ev_handshake[p] || ev_bad_frame[p] || ev_comwake[p]) |=>
      ((!$past(ev_crc[p])       || diag_q[p][DG_C]) &&
       (!$past(ev_handshake[p]) || diag_q[p][DG_H]) &&
       (!$past(ev_bad_frame[p]) || diag_q[p][DG_F]) &&
       (!$past(ev_comwake[p])   || diag_q[p][DG_W]))); // R4 R7

    AST_PHY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_ready[p] != $past(phy_ready[p])) |=> diag_q[p][DG_N]); // R5

    AST_NO_CLEAR_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> (($past(diag_q[p]) & ~diag_q[p]) == 16'h0)); // R6
  end

endmodule

bind sata_diag_err_regs sata_diag_err_chk #(
  .NUM_PORTS(NUM_PORTS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_decode   (ev_decode),
  .ev_disparity(ev_disparity),
  .ev_crc      (ev_crc),
  .ev_handshake(ev_handshake),
  .ev_bad_frame(ev_bad_frame),
  .ev_comwake  (ev_comwake),
  .phy_ready   (phy_ready),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .diag_q      (diag_q)
);

// File: tb/sata_diag_err_regs_bench.sv
module sata_diag_err_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int AW = 12;

  localparam logic [31:0] B_N = 32'h0001_0000;
  localparam logic [31:0] B_W = 32'h0004_0000;
  localparam logic [31:0] B_B = 32'h0008_0000;
  localparam logic [31:0] B_C = 32'h0020_0000;
  localparam logic [31:0] B_H = 32'h0040_0000;
  localparam logic [31:0] B_F = 32'h0200_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] ev_decode = '0, ev_disparity = '0, ev_crc = '0;
  logic [NP-1:0] ev_handshake = '0, ev_bad_frame = '0, ev_comwake = '0;
  logic [NP-1:0] phy_ready = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sata_diag_err_regs #(.NUM_PORTS(NP), .ADDR_W(AW)) u_sata_diag_err_regs (
    .clk(clk), .rst_n(rst_n),
    .ev_decode(ev_decode), .ev_disparity(ev_disparity), .ev_crc(ev_crc),
    .ev_handshake(ev_handshake), .ev_bad_frame(ev_bad_frame),
    .ev_comwake(ev_comwake), .phy_ready(phy_ready),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compare the read data one cycle after each read strobe
  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read result: actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input int addr, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = AW'(addr);
    bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    bus_addr = AW'(addr);
    bus_wdata = data;
    bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
    bus_wdata = '0;
  endtask

  // kind: 0 decode 1 disparity 2 crc 3 handshake 4 frame 5 comwake
  task automatic pulse(input int kind, input int p);
    case (kind)
      0: ev_decode[p] = 1'b1;
      1: ev_disparity[p] = 1'b1;
      2: ev_crc[p] = 1'b1;
      3: ev_handshake[p] = 1'b1;
      4: ev_bad_frame[p] = 1'b1;
      default: ev_comwake[p] = 1'b1;
    endcase
    tick();
    ev_decode = '0; ev_disparity = '0; ev_crc = '0;
    ev_handshake = '0; ev_bad_frame = '0; ev_comwake = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd('h108, 32'h0, "R1 port0 after reset");
    rd('h388, 32'h0, "R1 port3 after reset");

    // R4 / R8 single events at each port offset
    pulse(2, 0);
    rd('h108, B_C, "R4 crc sets C (R8 port0 at 0x108)");
    pulse(1, 1);
    rd('h188, B_B, "R3 disparity sets B, D zero (R8 port1 at 0x188)");
    pulse(0, 2);
    rd('h308, B_B, "R3 decode sets B (R8 port2 at 0x308)");
    pulse(3, 3); pulse(4, 3); pulse(5, 3);
    rd('h388, B_H | B_F | B_W, "R4 H F W latched (R8 port3 at 0x388)");
    rd('h388, B_H | B_F | B_W, "R4 bits sticky on reread");

    // R5 both edges of phy ready
    phy_ready[0] = 1'b1; tick();
    rd('h108, B_C | B_N, "R5 rising edge sets N");
    wr('h108, B_N);
    rd('h108, B_C, "R6 write-1 clears N only");
    phy_ready[0] = 1'b0; tick();
    rd('h108, B_C | B_N, "R5 falling edge sets N");

    // R6 zeros ignored, other ports untouched
    wr('h108, 32'h0);
    rd('h108, B_C | B_N, "R6 write of zero leaves bits");
    wr('h188, 32'hFFFF_FFFF);
    rd('h188, 32'h0, "R6 write all ones clears port1");
    rd('h108, B_C | B_N, "R6 port0 unaffected by port1 clear");

    // R9 unmapped offsets
    wr('h10C, 32'hFFFF_FFFF);
    wr('h208, 32'hFFFF_FFFF);
    rd('h308, B_B, "R9 unmapped writes leave port2");
    rd('h100, 32'h0, "R9 unmapped read 0x100");
    rd('h208, 32'h0, "R9 unmapped read 0x208");

    // R7 event and clear in the same cycle
    ev_crc[2] = 1'b1;
    wr('h308, 32'hFFFF_FFFF);
    ev_crc = '0;
    rd('h308, B_C, "R7 same-cycle event survives clear");

    // R2 every source at once on port1
    ev_decode[1] = 1'b1; ev_disparity[1] = 1'b1; ev_crc[1] = 1'b1;
    ev_handshake[1] = 1'b1; ev_bad_frame[1] = 1'b1; ev_comwake[1] = 1'b1;
    phy_ready[1] = 1'b1;
    tick();
    ev_decode = '0; ev_disparity = '0; ev_crc = '0;
    ev_handshake = '0; ev_bad_frame = '0; ev_comwake = '0;
    rd('h188, 32'h026D_0000, "R2 full set of implemented bits only");

    // R10 hold between reads
    wr('h388, 32'hFFFF_FFFF);
    rd('h388, 32'h0, "R10 port3 cleared");
    pulse(2, 3);
    tick(); tick();
    checks++;
    if (bus_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R10 hold without read: actual %h expected %h", bus_rdata, 32'h0);
    end
    rd('h388, B_C, "R10 next read shows new state");

    tick(); tick();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending reads: actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule